// File: doc/BRIEF.md
# SLIP-framed link packet receiver

This block sits behind a UART receiver and turns its byte stream back into link-layer packets. It looks for the frame marker byte, undoes the two-byte escape sequences that protect the marker and the escape byte, and gathers a four-byte packed header. It decodes the sequence and acknowledgement numbers, the reliability and checksum flags, the packet kind and a 12-bit body length. The body bytes are then passed on as a byte stream with first and last markers.

When the closing marker arrives, the block either accepts the frame with a one-cycle done pulse or discards it with a one-cycle drop pulse. A frame is accepted only if it is well formed and, when it is reliable, its sequence number equals the value that the reliability tracker drives on `exp_seq`. The header fields stay on the outputs from the end of the header until the next header completes. The acknowledgement number carried in the frame is among them and goes to the transmit side. Body bytes leave the block as they arrive. A frame that is later dropped may therefore already have put out some bytes, so the consumer must hold its result until the done or drop pulse.

Top module: `slip_link_rx`

## Requirements
- R1: Inside a frame, escape byte 0xDB followed by 0xDC decodes to 0xC0, and 0xDB followed by 0xDD decodes to 0xDB. This applies to header bytes and to body bytes.
- R2: 0xDB followed by any byte other than 0xDC or 0xDD pulses `pkt_drop` and returns the parser to idle. In idle only a 0xC0 starts a new header.
- R3: In idle, bytes other than 0xC0 are ignored. A 0xC0 that arrives while a header is being collected restarts the header count, so back-to-back markers are tolerated.
- R4: The header fields are placed as follows. Header byte 0 carries seq in bits 2:0, ack in bits 5:3, the checksum-present flag in bit 6 and the reliable flag in bit 7. Byte 1 carries the packet kind in bits 3:0.
- R5: The body length is byte1[7:4] + (byte2 << 4). A frame of length zero goes straight to the closing-marker check, with no body output.
- R6: Each body byte appears on `out_data` with `out_valid` for one cycle. `out_first` marks the first body byte and `out_last` marks the byte that completes the length. `pay_count` gives the number of body bytes put out in the current frame.
- R7: Only kinds 0, 2, 4, 5 and 15 forward a body. For any other kind the parser skips to the closing-marker check. With a nonzero length the first body byte then causes a drop; with length zero the frame is accepted.
- R8: While the closing marker is expected, any other byte pulses `pkt_drop`.
- R9: A reliable frame (bit 7 set) whose seq differs from `exp_seq` is dropped when its closing marker arrives. For an unreliable frame seq is not compared.
- R10: An accepted frame raises `pkt_done` for exactly one cycle, never together with `pkt_drop`. The fields `pkt_type`, `pkt_rel`, `pkt_seq`, `pkt_ack` and `pkt_crc` belong to that frame.
- R11: A body byte that arrives when `pay_count` already equals MAX_PAY is not put out. It pulses `ovf_err` and `pkt_drop`, and the parser returns to idle.
- R12: `hdr_sum_err` is 1 when header byte 3 differs from the bitwise inverse of the 8-bit sum of bytes 0 to 2. This flag does not change whether the frame is accepted.
- R13: An unescaped 0xC0 that arrives before the body is complete drops the frame and starts collecting a new header at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| exp_seq | input | 3 | Next expected reliable sequence number |
| out_valid | output | 1 | Body byte strobe |
| out_data | output | 8 | Decoded body byte |
| out_first | output | 1 | First body byte of a frame |
| out_last | output | 1 | Last body byte of a frame |
| pkt_done | output | 1 | Frame accepted (one cycle) |
| pkt_drop | output | 1 | Frame discarded (one cycle) |
| pkt_type | output | 4 | Packet kind |
| pkt_rel | output | 1 | Reliable flag |
| pkt_seq | output | 3 | Sequence number |
| pkt_ack | output | 3 | Piggybacked acknowledgement number |
| pkt_crc | output | 1 | Checksum-present flag |
| pay_count | output | 12 | Body bytes put out in the current frame |
| ovf_err | output | 1 | Body longer than MAX_PAY (one cycle) |
| hdr_sum_err | output | 1 | Header checksum mismatch |

## Verification
The bench sends clean frames with distinct seq, ack, kind and length values, so that a misplaced bit field or a wrong nibble in the length shows up. Frames with escaped bytes, including an escaped marker in the header itself, separate correct unescaping from raw pass-through. Malformed streams cover each error path and show which errors drop the frame and which resynchronise. These are a bad escape, a missing closing marker, an early marker, an unknown kind and an overlong body. Frames with a matching and a mismatching seq, sent reliable and unreliable, together with a frame that has a bad checksum, show that only the sequence check decides whether a frame is accepted.

// File: rtl/slip_link_rx_pkg.sv
package slip_link_rx_pkg;

    localparam logic [7:0] FRAME_MARK = 8'hC0;
    localparam logic [7:0] ESC_LEAD   = 8'hDB;
    localparam logic [7:0] ESC_MARK   = 8'hDC;
    localparam logic [7:0] ESC_SELF   = 8'hDD;

    localparam int LEN_W  = 12;
    localparam int SEQ_W  = 3;
    localparam int KIND_W = 4;
    localparam int HDR_W  = 2;   // index width for the four header bytes

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_BODY,
        ST_TAIL
    } rx_state_e;

    typedef struct packed {
        logic              rel;
        logic              crc;
        logic [SEQ_W-1:0]  ack;
        logic [SEQ_W-1:0]  seq;
        logic [KIND_W-1:0] kind;
        logic [LEN_W-1:0]  len;
    } hdr_fields_t;

    typedef struct packed {
        rx_state_e         st;
        logic [HDR_W-1:0]  idx;
        logic [7:0]        b0;
        logic [7:0]        b1;
        logic [7:0]        b2;
        logic [LEN_W-1:0]  remain;
        logic [LEN_W-1:0]  cnt;
        hdr_fields_t       f;
        logic              sum_bad;
        logic              ov;
        logic              of;
        logic              ol;
        logic [7:0]        od;
        logic              done;
        logic              drop;
        logic              ovf;
    } rx_regs_t;

endpackage

// File: rtl/slip_unescape.sv
module slip_unescape
    import slip_link_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       dec_valid,
    output logic [7:0] dec_data,
    output logic       mark,
    output logic       esc_err
);

    logic pend_d, pend_q;

    always_comb begin
        pend_d    = pend_q;
        dec_valid = 1'b0;
        dec_data  = in_data;
        mark      = 1'b0;
        esc_err   = 1'b0;
        if (!en) begin
            pend_d = 1'b0;
        end else if (in_valid) begin
            if (pend_q) begin
                pend_d = 1'b0;
                if (in_data == ESC_MARK) begin
                    dec_valid = 1'b1;
                    dec_data  = FRAME_MARK;
                end else if (in_data == ESC_SELF) begin
                    dec_valid = 1'b1;
                    dec_data  = ESC_LEAD;
                end else begin
                    esc_err = 1'b1;
                end
            end else if (in_data == FRAME_MARK) begin
                mark = 1'b1;
            end else if (in_data == ESC_LEAD) begin
                pend_d = 1'b1;
            end else begin
                dec_valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R1: a byte following a pending escape always produces a decode or an error
    a_r1_escape_resolves: assert property (@(posedge clk) disable iff (!rst_n)
        (en && in_valid && pend_q) |-> (dec_valid || esc_err));

    // R2: an escape error only follows a lead byte that was accepted earlier
    a_r2_err_needs_lead: assert property (@(posedge clk) disable iff (!rst_n)
        esc_err |-> !mark && !dec_valid && in_valid);

endmodule

// File: rtl/slip_hdr_decode.sv
module slip_hdr_decode
    import slip_link_rx_pkg::*;
#(
    parameter logic [15:0] ACCEPT_MASK = 16'h8035
) (
    input  logic [7:0]  b0,
    input  logic [7:0]  b1,
    input  logic [7:0]  b2,
    input  logic [7:0]  b3,
    output hdr_fields_t fields,
    output logic        known,
    output logic        sum_bad
);

    localparam int NKIND = 1 << KIND_W;

    logic [NKIND-1:0] hit;
    logic [7:0]       sum;

    for (genvar t = 0; t < NKIND; t++) begin : g_kind
        assign hit[t] = ACCEPT_MASK[t] && (b1[KIND_W-1:0] == KIND_W'(t));
    end

    assign known = |hit;

    always_comb begin
        fields.seq  = b0[2:0];
        fields.ack  = b0[5:3];
        fields.crc  = b0[6];
        fields.rel  = b0[7];
        fields.kind = b1[3:0];
        fields.len  = {b2, b1[7:4]};
        sum         = b0 + b1 + b2;
        sum_bad     = (b3 != ~sum);
    end

endmodule

// File: rtl/slip_link_rx.sv
module slip_link_rx
    import slip_link_rx_pkg::*;
#(
    parameter int          MAX_PAY     = 64,
    parameter logic [15:0] ACCEPT_MASK = 16'h8035
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic [SEQ_W-1:0]  exp_seq,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              pkt_done,
    output logic              pkt_drop,
    output logic [KIND_W-1:0] pkt_type,
    output logic              pkt_rel,
    output logic [SEQ_W-1:0]  pkt_seq,
    output logic [SEQ_W-1:0]  pkt_ack,
    output logic              pkt_crc,
    output logic [LEN_W-1:0]  pay_count,
    output logic              ovf_err,
    output logic              hdr_sum_err
);

    localparam logic [LEN_W-1:0] MAX_CNT  = LEN_W'(MAX_PAY);
    localparam logic [HDR_W-1:0] LAST_HDR = HDR_W'(3);

    rx_regs_t    d, q;
    logic        u_en, u_valid, u_mark, u_err;
    logic [7:0]  u_data;
    hdr_fields_t dec_f;
    logic        dec_known, dec_sum_bad;

    assign u_en = (q.st == ST_HDR) || (q.st == ST_BODY);

    slip_unescape u_unesc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (u_en),
        .in_valid (in_valid),
        .in_data  (in_data),
        .dec_valid(u_valid),
        .dec_data (u_data),
        .mark     (u_mark),
        .esc_err  (u_err)
    );

    slip_hdr_decode #(.ACCEPT_MASK(ACCEPT_MASK)) u_hdr (
        .b0     (q.b0),
        .b1     (q.b1),
        .b2     (q.b2),
        .b3     (u_data),
        .fields (dec_f),
        .known  (dec_known),
        .sum_bad(dec_sum_bad)
    );

    always_comb begin
        d      = q;
        d.ov   = 1'b0;
        d.of   = 1'b0;
        d.ol   = 1'b0;
        d.done = 1'b0;
        d.drop = 1'b0;
        d.ovf  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (in_valid && in_data == FRAME_MARK) begin
                    d.st  = ST_HDR;
                    d.idx = '0;
                end
            end
            ST_HDR: begin
                if (u_mark) begin
                    d.idx = '0;
                end else if (u_err) begin
                    d.st   = ST_IDLE;
                    d.drop = 1'b1;
                end else if (u_valid) begin
                    unique case (q.idx)
                        2'd0:    d.b0 = u_data;
                        2'd1:    d.b1 = u_data;
                        2'd2:    d.b2 = u_data;
                        default: ;
                    endcase
                    if (q.idx == LAST_HDR) begin
                        d.f       = dec_f;
                        d.sum_bad = dec_sum_bad;
                        d.cnt     = '0;
                        d.remain  = dec_f.len;
                        if (dec_f.len == '0 || !dec_known) d.st = ST_TAIL;
                        else                               d.st = ST_BODY;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_BODY: begin
                if (u_mark) begin
                    d.drop = 1'b1;
                    d.st   = ST_HDR;
                    d.idx  = '0;
                end else if (u_err) begin
                    d.drop = 1'b1;
                    d.st   = ST_IDLE;
                end else if (u_valid) begin
                    if (q.cnt == MAX_CNT) begin
                        d.ovf  = 1'b1;
                        d.drop = 1'b1;
                        d.st   = ST_IDLE;
                    end else begin
                        d.ov     = 1'b1;
                        d.od     = u_data;
                        d.of     = (q.cnt == '0);
                        d.ol     = (q.remain == LEN_W'(1));
                        d.cnt    = q.cnt + 1'b1;
                        d.remain = q.remain - 1'b1;
                        if (q.remain == LEN_W'(1)) d.st = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (in_valid) begin
                    d.st = ST_IDLE;
                    if (in_data != FRAME_MARK)                  d.drop = 1'b1;
                    else if (q.f.rel && q.f.seq != exp_seq)     d.drop = 1'b1;
                    else                                        d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign out_valid   = q.ov;
    assign out_data    = q.od;
    assign out_first   = q.of;
    assign out_last    = q.ol;
    assign pkt_done    = q.done;
    assign pkt_drop    = q.drop;
    assign pkt_type    = q.f.kind;
    assign pkt_rel     = q.f.rel;
    assign pkt_seq     = q.f.seq;
    assign pkt_ack     = q.f.ack;
    assign pkt_crc     = q.f.crc;
    assign pay_count   = q.cnt;
    assign ovf_err     = q.ovf;
    assign hdr_sum_err = q.sum_bad;

    a_r10_done_drop_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_done && pkt_drop));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    a_r11_ovf_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> pkt_drop && !out_valid);

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        pay_count <= MAX_CNT);

    a_r9_seq_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_done && pkt_rel) |-> (pkt_seq == $past(exp_seq)));

    a_r6_first_count: assert property (@(posedge clk) disable iff (!rst_n)
        out_first |-> (out_valid && pay_count == LEN_W'(1)));

    a_r6_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_first) |-> (pay_count == $past(pay_count) + LEN_W'(1)));

endmodule

// File: tb/slip_link_rx_bench.sv
module slip_link_rx_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAXP       = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [2:0]  exp_seq = 3'd0;
    logic        out_valid, out_first, out_last, pkt_done, pkt_drop;
    logic [7:0]  out_data;
    logic [3:0]  pkt_type;
    logic        pkt_rel, pkt_crc, ovf_err, hdr_sum_err;
    logic [2:0]  pkt_seq, pkt_ack;
    logic [11:0] pay_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    slip_link_rx #(.MAX_PAY(MAXP)) u_slip_link_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .exp_seq(exp_seq), .out_valid(out_valid), .out_data(out_data),
        .out_first(out_first), .out_last(out_last), .pkt_done(pkt_done),
        .pkt_drop(pkt_drop), .pkt_type(pkt_type), .pkt_rel(pkt_rel),
        .pkt_seq(pkt_seq), .pkt_ack(pkt_ack), .pkt_crc(pkt_crc),
        .pay_count(pay_count), .ovf_err(ovf_err), .hdr_sum_err(hdr_sum_err)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // monitor: counts only grow
    int         n_out = 0, n_done = 0, n_drop = 0, n_ovf = 0;
    logic [7:0] cap  [0:63];
    logic       capf [0:63];
    logic       capl [0:63];
    logic [3:0] m_type;
    logic       m_rel, m_crc, m_sum;
    logic [2:0] m_seq, m_ack;

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                cap[n_out % 64]  = out_data;
                capf[n_out % 64] = out_first;
                capl[n_out % 64] = out_last;
                n_out++;
            end
            if (pkt_done) begin
                n_done++;
                m_type = pkt_type; m_rel = pkt_rel; m_crc = pkt_crc;
                m_seq = pkt_seq; m_ack = pkt_ack; m_sum = hdr_sum_err;
            end
            if (pkt_drop) n_drop++;
            if (ovf_err)  n_ovf++;
        end
    end

    logic [7:0] pl [0:31];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic put_esc(input logic [7:0] b);
        if (b == 8'hC0) begin put(8'hDB); put(8'hDC); end
        else if (b == 8'hDB) begin put(8'hDB); put(8'hDD); end
        else put(b);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic send_frame(input logic rel, input logic crc, input logic [2:0] seq,
                              input logic [2:0] ack, input logic [3:0] kind,
                              input logic [11:0] len, input int nsend,
                              input bit open, input bit close, input bit bad_sum);
        logic [7:0] b0, b1, b2, b3;
        b0 = {rel, crc, ack, seq};
        b1 = {len[3:0], kind};
        b2 = len[11:4];
        b3 = ~(b0 + b1 + b2);
        if (bad_sum) b3 = b3 ^ 8'h01;
        if (open) put(8'hC0);
        put_esc(b0); put_esc(b1); put_esc(b2); put_esc(b3);
        for (int i = 0; i < nsend; i++) put_esc(pl[i]);
        if (close) put(8'hC0);
        settle();
    endtask

    task automatic t_reset();
        #1;
        chk(out_valid == 0 && pkt_done == 0 && pkt_drop == 0, "R10 reset outputs idle",
            {out_valid, pkt_done, pkt_drop}, 0);
        chk(pay_count == 0, "R6 reset count", pay_count, 0);
    endtask

    task automatic t_basic();
        int o0 = n_out, d0 = n_done;
        pl[0] = 8'h11; pl[1] = 8'h22; pl[2] = 8'h33;
        exp_seq = 3'd2;
        send_frame(1, 0, 3'd2, 3'd5, 4'd2, 12'd3, 3, 1, 1, 0);
        chk(n_done == d0 + 1, "R10 basic accepted", n_done - d0, 1);
        chk(n_out == o0 + 3, "R6 basic byte count", n_out - o0, 3);
        chk(cap[o0 % 64] == 8'h11 && cap[(o0+2) % 64] == 8'h33, "R6 basic data",
            cap[(o0+2) % 64], 8'h33);
        chk(capf[o0 % 64] && !capf[(o0+1) % 64] && capl[(o0+2) % 64] && !capl[(o0+1) % 64],
            "R6 first/last markers", {capf[o0 % 64], capl[(o0+2) % 64]}, 3);
        chk(m_type == 2 && m_rel && !m_crc && m_seq == 2 && m_ack == 5, "R4 fields",
            {m_type, m_rel, m_crc, m_seq, m_ack}, {4'd2, 1'b1, 1'b0, 3'd2, 3'd5});
        chk(pay_count == 3, "R6 pay_count", pay_count, 3);
        chk(m_sum == 0, "R12 good checksum", m_sum, 0);
    endtask

    task automatic t_fields2();
        int d0 = n_done;
        pl[0] = 8'h5A;
        exp_seq = 3'd6;
        send_frame(1, 1, 3'd6, 3'd3, 4'd5, 12'd1, 1, 1, 1, 0);
        chk(n_done == d0 + 1, "R4 second pattern accepted", n_done - d0, 1);
        chk(m_type == 5 && m_crc && m_seq == 6 && m_ack == 3, "R4 second field pattern",
            {m_type, m_crc, m_seq, m_ack}, {4'd5, 1'b1, 3'd6, 3'd3});
    endtask

    task automatic t_escapes();
        int o0 = n_out, d0 = n_done;
        pl[0] = 8'hC0; pl[1] = 8'hDB; pl[2] = 8'h7E;
        exp_seq = 3'd0;
        // header byte 0 is 0xC0 itself and travels escaped
        send_frame(1, 1, 3'd0, 3'd0, 4'd4, 12'd3, 3, 1, 1, 0);
        chk(n_done == d0 + 1, "R1 escaped frame accepted", n_done - d0, 1);
        chk(n_out == o0 + 3, "R1 escaped byte count", n_out - o0, 3);
        chk(cap[o0 % 64] == 8'hC0, "R1 escaped marker decoded", cap[o0 % 64], 8'hC0);
        chk(cap[(o0+1) % 64] == 8'hDB, "R1 escaped escape decoded", cap[(o0+1) % 64], 8'hDB);
        chk(m_type == 4 && m_rel && m_crc, "R1 escaped header fields", m_type, 4);
    endtask

    task automatic t_zero_len();
        int o0 = n_out, d0 = n_done;
        send_frame(0, 0, 3'd1, 3'd2, 4'd15, 12'd0, 0, 1, 1, 0);
        chk(n_done == d0 + 1, "R5 zero length accepted", n_done - d0, 1);
        chk(n_out == o0, "R5 zero length no body", n_out - o0, 0);
        chk(m_type == 15 && m_ack == 2, "R5 zero length fields", m_type, 15);
    endtask

    task automatic t_long_len();
        int o0 = n_out, d0 = n_done;
        for (int i = 0; i < 16; i++) pl[i] = 8'(i + 1);
        // length 16 = byte1 high nibble 0, byte2 = 1
        send_frame(0, 0, 3'd0, 3'd0, 4'd2, 12'd16, 16, 1, 1, 0);
        chk(n_done == d0 + 1 && n_out == o0 + 16, "R5 length uses byte2", n_out - o0, 16);
        chk(capl[(o0+15) % 64] && !capl[(o0+14) % 64], "R5 last at byte 16",
            capl[(o0+15) % 64], 1);
    endtask

    task automatic t_bad_escape();
        int d0 = n_done, p0 = n_drop;
        put(8'hC0); put(8'h00); put(8'hDB); put(8'h41);
        put(8'h12); put(8'h34);
        settle();
        chk(n_drop == p0 + 1, "R2 bad escape drops", n_drop - p0, 1);
        chk(n_done == d0, "R2 garbage after error not accepted", n_done - d0, 0);
        send_frame(0, 0, 3'd0, 3'd1, 4'd15, 12'd0, 0, 1, 1, 0);
        chk(n_done == d0 + 1, "R2 recovers on next frame", n_done - d0, 1);
    endtask

    task automatic t_back_to_back();
        int d0 = n_done, p0 = n_drop;
        put(8'h55); put(8'hAA); put(8'hC0); put(8'hC0);
        send_frame(0, 0, 3'd0, 3'd4, 4'd0, 12'd0, 0, 1, 1, 0);
        chk(n_done == d0 + 1 && n_drop == p0, "R3 repeated markers tolerated", n_done - d0, 1);
        chk(m_ack == 4 && m_type == 0, "R3 header aligned after markers", m_ack, 4);
    endtask

    task automatic t_unknown();
        int o0 = n_out, d0 = n_done, p0 = n_drop;
        pl[0] = 8'h01; pl[1] = 8'h02;
        send_frame(0, 0, 3'd0, 3'd0, 4'd7, 12'd2, 2, 1, 1, 0);
        chk(n_drop == p0 + 1 && n_done == d0, "R7 unknown kind with body drops",
            n_drop - p0, 1);
        chk(n_out == o0, "R7 unknown kind no body out", n_out - o0, 0);
        put(8'hC0);
        send_frame(0, 0, 3'd0, 3'd0, 4'd7, 12'd0, 0, 1, 1, 0);
        chk(n_done == d0 + 1 && m_type == 7, "R7 unknown kind zero length accepted",
            n_done - d0, 1);
    endtask

    task automatic t_no_close();
        int d0 = n_done, p0 = n_drop;
        pl[0] = 8'h99; pl[1] = 8'h77;
        send_frame(0, 0, 3'd0, 3'd0, 4'd2, 12'd1, 2, 1, 0, 0);
        chk(n_drop == p0 + 1 && n_done == d0, "R8 missing closing marker drops",
            n_drop - p0, 1);
    endtask

    task automatic t_seq();
        int d0 = n_done, p0 = n_drop;
        pl[0] = 8'h44;
        exp_seq = 3'd2;
        send_frame(1, 0, 3'd3, 3'd0, 4'd2, 12'd1, 1, 1, 1, 0);
        chk(n_drop == p0 + 1 && n_done == d0, "R9 reliable seq mismatch drops",
            n_drop - p0, 1);
        send_frame(0, 0, 3'd3, 3'd0, 4'd2, 12'd1, 1, 1, 1, 0);
        chk(n_done == d0 + 1 && n_drop == p0 + 1, "R9 unreliable seq ignored",
            n_done - d0, 1);
    endtask

    task automatic t_overflow();
        int o0 = n_out, p0 = n_drop, v0 = n_ovf, d0 = n_done;
        for (int i = 0; i < 20; i++) pl[i] = 8'(8'h20 + i);
        send_frame(0, 0, 3'd0, 3'd0, 4'd2, 12'd20, 20, 1, 1, 0);
        chk(n_ovf == v0 + 1, "R11 overflow flagged", n_ovf - v0, 1);
        chk(n_out == o0 + MAXP, "R11 bytes limited to maximum", n_out - o0, MAXP);
        chk(n_drop == p0 + 1 && n_done == d0, "R11 overflow drops", n_drop - p0, 1);
        chk(pay_count == MAXP, "R11 count stops at maximum", pay_count, MAXP);
    endtask

    task automatic t_checksum();
        int d0 = n_done;
        send_frame(0, 1, 3'd0, 3'd6, 4'd15, 12'd0, 0, 1, 1, 1);
        chk(n_done == d0 + 1, "R12 bad checksum still accepted", n_done - d0, 1);
        chk(m_sum == 1, "R12 checksum mismatch flagged", m_sum, 1);
    endtask

    task automatic t_early_mark();
        int d0 = n_done, p0 = n_drop;
        pl[0] = 8'h61; pl[1] = 8'h62;
        send_frame(0, 0, 3'd0, 3'd0, 4'd2, 12'd4, 2, 1, 1, 0);
        chk(n_drop == p0 + 1 && n_done == d0, "R13 early marker drops", n_drop - p0, 1);
        // the early marker already opened a new header
        send_frame(0, 0, 3'd0, 3'd7, 4'd0, 12'd0, 0, 0, 1, 0);
        chk(n_done == d0 + 1 && m_ack == 7, "R13 header starts after early marker",
            n_done - d0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        settle();
        t_basic();
        t_fields2();
        t_escapes();
        t_zero_len();
        t_long_len();
        t_bad_escape();
        t_back_to_back();
        t_unknown();
        t_no_close();
        t_seq();
        t_overflow();
        t_checksum();
        t_early_mark();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule